// File: doc/BRIEF.md
# Supply Supervisor and Reset Sequencer

This block watches three digitised supply comparator flags: supply below the early-warning level, below the minimum operating level, and below the backup-cell voltage. From these it decides when the processor core may run. A falling supply first produces a one-cycle warning interrupt request that carries a fixed vector of 2Bh, and code keeps running. A supply below the minimum operating level holds the core in reset. That reset stays asserted until the supply has recovered and a long power-on delay has been counted.

The reset indication is an open-drain line shared between devices. This block pulls it low while the supply is too low. Any other device that pulls it low also resets this one, so a group of controllers leaves reset together. An active-high external reset input has the same effect. A separate active-low output reports that the part is running from its backup cell. A bootstrap-program request pin is filtered in both directions. It produces a level request and a one-cycle start pulse when the filtered pin falls.

Every asynchronous input passes through a two-flop synchroniser. Clearing `arst_ni` puts the block in a safe state that treats the supply as low. That input is the block's own power-on clear, taken from the always-powered domain.

Top module: `pwr_seq_top`

## Requirements
- R1: While `arst_ni` is low and in the first cycle after it rises, `core_rst_o` is 1, `rst_pad_drive_o` is 1, `batt_mode_n_o` is 0, and `warn_irq_o`, `warn_vec_o`, `boot_req_o` and `boot_start_o` are 0.
- R2: Each asynchronous input passes two flip-flops before any use. A change on `below_min_i` reaches `rst_pad_drive_o` at the second rising clock edge and not at the first.
- R3: While the synchronised minimum-level or backup-level flag is 1, `rst_pad_drive_o` is 1 (pad pulled low) and `core_rst_o` is 1 from the next cycle.
- R4: `core_rst_o` falls only after exactly `POR_CYCLES` consecutive clock cycles in which no reset cause is present. The default is 21504.
- R5: Any reset cause that appears during the power-on count restarts the count from zero, even if it lasts only one cycle.
- R6: `ext_rst_i` = 1 forces `core_rst_o` to 1 but does not drive the shared pad (`rst_pad_drive_o` stays 0).
- R7: A low level on `rst_pad_i` caused by another device forces `core_rst_o` to 1. The power-on count then restarts.
- R8: A 0-to-1 transition of the synchronised warning flag, with `warn_en_i` = 1, produces `warn_irq_o` high for exactly one cycle. In that cycle `warn_vec_o` = 8'h2B. At all other times `warn_vec_o` = 0.
- R9: No warning request is made while `warn_en_i` = 0 or while `core_rst_o` = 1. A held warning level produces only one request. A new request needs the flag to return to 0 first.
- R10: `batt_mode_n_o` is the inverse of the synchronised backup-level flag (0 = running on the backup cell).
- R11: `boot_req_o` becomes 1 only after the synchronised `prog_n_i` has been 0 for `FILT_CYCLES` consecutive cycles (default 48). It returns to 0 only after `FILT_CYCLES` consecutive cycles of 1. Shorter pulses are ignored.
- R12: `boot_start_o` is a one-cycle pulse in the cycle where `boot_req_o` rises. It does not pulse when `boot_req_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Block power-on clear, active low, asynchronous |
| ext_rst_i | input | 1 | External reset request, active high, asynchronous |
| below_warn_i | input | 1 | Comparator: supply below warning level |
| below_min_i | input | 1 | Comparator: supply below minimum operating level |
| below_batt_i | input | 1 | Comparator: supply below backup-cell voltage |
| warn_en_i | input | 1 | Enables the warning interrupt request |
| rst_pad_i | input | 1 | Sensed level of the shared open-drain reset line |
| rst_pad_drive_o | output | 1 | 1 = pull the shared reset line low |
| core_rst_o | output | 1 | Core reset, active high |
| warn_irq_o | output | 1 | One-cycle warning interrupt request |
| warn_vec_o | output | 8 | Vector for the warning request, 2Bh while requesting |
| batt_mode_n_o | output | 1 | 0 = supply below the backup cell voltage |
| prog_n_i | input | 1 | Bootstrap-program request pin, active low, asynchronous |
| boot_req_o | output | 1 | Filtered program request, active high |
| boot_start_o | output | 1 | One-cycle pulse when the filtered request asserts |

## Verification
The assertions check every cycle that a supply-related or pad cause puts the core in reset on the next cycle. They also check that reset falls only at the end of a quiet window exactly `POR_CYCLES` long, with that window measured by a checker counter. Further per-cycle checks cover the single-cycle warning and boot pulses, the absence of warnings during reset, and the filter holding its output while the pin agrees with it. The bench scenarios show what a local property cannot. These are the two-edge synchroniser latency, a one-cycle external reset restarting a count that is already part-way through, and the pad loop with another device pulling the line. The bench scenarios also show re-arming of the warning after the supply recovers and the rejection of program-pin glitches shorter than the filter window.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Bit positions of the asynchronous inputs in the synchroniser vector
    localparam int NUM_ASYNC = 6;
    localparam int IDX_WARN  = 0;
    localparam int IDX_MIN   = 1;
    localparam int IDX_BATT  = 2;
    localparam int IDX_EXT   = 3;
    localparam int IDX_PAD   = 4;
    localparam int IDX_PROG  = 5;

    // Safe values after clear: supply treated as low, pad and program pin high
    localparam logic [NUM_ASYNC-1:0] SYNC_CLEAR_VAL = 6'b11_0111;

    localparam int          DEF_POR_CYCLES  = 21504;
    localparam int          DEF_FILT_CYCLES = 48;
    localparam int          DEF_SYNC_STAGES = 2;
    localparam logic [7:0]  WARN_VECTOR     = 8'h2B;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   CLR_VAL = '0
) (
    input  logic             clk_i,
    input  logic             arst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            chain_q <= {STAGES{CLR_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_rstgen.sv
module pwr_seq_rstgen #(
    parameter int         POR_CYCLES = 21504,
    parameter logic [7:0] VEC        = 8'h2B
) (
    input  logic       clk_i,
    input  logic       arst_ni,
    input  logic       below_warn_i,
    input  logic       below_min_i,
    input  logic       below_batt_i,
    input  logic       ext_rst_i,
    input  logic       pad_high_i,
    input  logic       warn_en_i,
    output logic       core_rst_o,
    output logic       pad_drive_o,
    output logic       warn_irq_o,
    output logic [7:0] warn_vec_o
);

    localparam int              CW   = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CW-1:0]   LAST = CW'(POR_CYCLES - 1);

    typedef struct packed {
        logic          core_rst;
        logic [CW-1:0] cnt;
        logic          warn_prev;
        logic          irq;
    } rst_state_t;

    localparam rst_state_t CLR_ST = '{core_rst: 1'b1, cnt: '0, warn_prev: 1'b1, irq: 1'b0};

    rst_state_t st_d, st_q;
    logic supply_low, any_cause, warn_cross;

    always_comb begin
        supply_low = below_min_i | below_batt_i;
        any_cause  = supply_low | ext_rst_i | ~pad_high_i;
        warn_cross = below_warn_i & ~st_q.warn_prev;

        st_d           = st_q;
        st_d.warn_prev = below_warn_i;
        st_d.irq       = warn_cross & warn_en_i & ~st_q.core_rst;

        if (any_cause) begin
            st_d.core_rst = 1'b1;
            st_d.cnt      = '0;
        end else if (st_q.core_rst) begin
            if (st_q.cnt == LAST) begin
                st_d.core_rst = 1'b0;
                st_d.cnt      = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            st_q <= CLR_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_rst_o  = st_q.core_rst;
    assign pad_drive_o = supply_low;
    assign warn_irq_o  = st_q.irq;
    assign warn_vec_o  = st_q.irq ? VEC : 8'h00;

    // Checker: length of the current run of cause-free cycles, saturating
    logic [CW:0] quiet_q;
    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            quiet_q <= '0;
        end else if (any_cause) begin
            quiet_q <= '0;
        end else if (quiet_q < (CW+1)'(POR_CYCLES)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_cause_forces_reset_R3: assert property (@(posedge clk_i) disable iff (!arst_ni)
        any_cause |=> core_rst_o);

    assert_release_after_quiet_R4: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(core_rst_o) |-> (quiet_q == (CW+1)'(POR_CYCLES)));

    assert_irq_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!arst_ni)
        warn_irq_o |=> !warn_irq_o);

    assert_irq_not_in_reset_R9: assert property (@(posedge clk_i) disable iff (!arst_ni)
        warn_irq_o |-> !$past(core_rst_o));

endmodule

// File: rtl/pwr_seq_filter.sv
module pwr_seq_filter #(
    parameter int FILT_CYCLES = 48
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic pin_high_i,
    output logic req_o,
    output logic start_o
);

    localparam int            FW    = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [FW-1:0] FLAST = FW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic          level;
        logic [FW-1:0] cnt;
        logic          start;
    } filt_state_t;

    localparam filt_state_t CLR_ST = '{level: 1'b1, cnt: '0, start: 1'b0};

    filt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (pin_high_i != st_q.level) begin
            if (st_q.cnt == FLAST) begin
                st_d.level = pin_high_i;
                st_d.cnt   = '0;
                st_d.start = ~pin_high_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            st_q <= CLR_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = ~st_q.level;
    assign start_o = st_q.start;

    assert_filter_holds_R11: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (pin_high_i == st_q.level) |=> $stable(req_o));

    assert_start_one_cycle_R12: assert property (@(posedge clk_i) disable iff (!arst_ni)
        start_o |=> !start_o);

    assert_start_with_request_R12: assert property (@(posedge clk_i) disable iff (!arst_ni)
        start_o |-> (req_o && !$past(req_o)));

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int POR_CYCLES  = DEF_POR_CYCLES,
    parameter int FILT_CYCLES = DEF_FILT_CYCLES,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic       clk_i,
    input  logic       arst_ni,
    input  logic       ext_rst_i,
    input  logic       below_warn_i,
    input  logic       below_min_i,
    input  logic       below_batt_i,
    input  logic       warn_en_i,
    input  logic       rst_pad_i,
    output logic       rst_pad_drive_o,
    output logic       core_rst_o,
    output logic       warn_irq_o,
    output logic [7:0] warn_vec_o,
    output logic       batt_mode_n_o,
    input  logic       prog_n_i,
    output logic       boot_req_o,
    output logic       boot_start_o
);

    logic [NUM_ASYNC-1:0] async_vec, sync_vec;

    always_comb begin
        async_vec           = '0;
        async_vec[IDX_WARN] = below_warn_i;
        async_vec[IDX_MIN]  = below_min_i;
        async_vec[IDX_BATT] = below_batt_i;
        async_vec[IDX_EXT]  = ext_rst_i;
        async_vec[IDX_PAD]  = rst_pad_i;
        async_vec[IDX_PROG] = prog_n_i;
    end

    pwr_seq_sync #(
        .WIDTH   (NUM_ASYNC),
        .STAGES  (SYNC_STAGES),
        .CLR_VAL (SYNC_CLEAR_VAL)
    ) u_sync (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .async_i (async_vec),
        .sync_o  (sync_vec)
    );

    pwr_seq_rstgen #(
        .POR_CYCLES (POR_CYCLES),
        .VEC        (WARN_VECTOR)
    ) u_rstgen (
        .clk_i        (clk_i),
        .arst_ni      (arst_ni),
        .below_warn_i (sync_vec[IDX_WARN]),
        .below_min_i  (sync_vec[IDX_MIN]),
        .below_batt_i (sync_vec[IDX_BATT]),
        .ext_rst_i    (sync_vec[IDX_EXT]),
        .pad_high_i   (sync_vec[IDX_PAD]),
        .warn_en_i    (warn_en_i),
        .core_rst_o   (core_rst_o),
        .pad_drive_o  (rst_pad_drive_o),
        .warn_irq_o   (warn_irq_o),
        .warn_vec_o   (warn_vec_o)
    );

    pwr_seq_filter #(
        .FILT_CYCLES (FILT_CYCLES)
    ) u_filter (
        .clk_i      (clk_i),
        .arst_ni    (arst_ni),
        .pin_high_i (sync_vec[IDX_PROG]),
        .req_o      (boot_req_o),
        .start_o    (boot_start_o)
    );

    assign batt_mode_n_o = ~sync_vec[IDX_BATT];

    assert_pad_drive_resets_R3: assert property (@(posedge clk_i) disable iff (!arst_ni)
        rst_pad_drive_o |=> core_rst_o);

    assert_backup_mode_resets_R10: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !batt_mode_n_o |=> core_rst_o);

endmodule

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;

    localparam int POR  = 200;
    localparam int FILT = 48;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic ext_rst = 1'b0, b_warn = 1'b1, b_min = 1'b1, b_batt = 1'b1;
    logic warn_en = 1'b1, prog_n = 1'b1, other_low = 1'b0;
    logic pad, pad_drive, core_rst, irq, batt_n, boot_req, boot_start;
    logic [7:0] vec;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign pad = !(pad_drive | other_low);

    pwr_seq_top #(.POR_CYCLES(POR), .FILT_CYCLES(FILT)) u_pwr_seq_top (
        .clk_i(clk), .arst_ni(arst_n), .ext_rst_i(ext_rst),
        .below_warn_i(b_warn), .below_min_i(b_min), .below_batt_i(b_batt),
        .warn_en_i(warn_en), .rst_pad_i(pad), .rst_pad_drive_o(pad_drive),
        .core_rst_o(core_rst), .warn_irq_o(irq), .warn_vec_o(vec),
        .batt_mode_n_o(batt_n), .prog_n_i(prog_n), .boot_req_o(boot_req),
        .boot_start_o(boot_start)
    );

    // Behavioural reference model: input pipelines as two-entry queues
    bit q_warn[$], q_min[$], q_batt[$], q_ext[$], q_pad[$], q_prog[$];
    bit m_rst, m_irq, m_wprev, m_filt, m_start;
    int m_cnt, m_fcnt;

    task automatic model_clear();
        q_warn = '{1, 1}; q_min = '{1, 1}; q_batt = '{1, 1};
        q_ext = '{0, 0}; q_pad = '{1, 1}; q_prog = '{1, 1};
        m_rst = 1; m_cnt = 0; m_wprev = 1; m_irq = 0;
        m_filt = 1; m_fcnt = 0; m_start = 0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!arst_n) begin
            model_clear();
        end else begin
            bit w, mn, bt, ex, pd, pg, cause, low_pad;
            w = q_warn[0]; mn = q_min[0]; bt = q_batt[0];
            ex = q_ext[0]; pd = q_pad[0]; pg = q_prog[0];
            cause = mn | bt | ex | !pd;
            m_irq = w & !m_wprev & warn_en & !m_rst;
            m_wprev = w;
            if (cause) begin
                m_rst = 1; m_cnt = 0;
            end else if (m_rst) begin
                if (m_cnt == POR - 1) begin m_rst = 0; m_cnt = 0; end
                else m_cnt++;
            end
            m_start = 0;
            if (pg != m_filt) begin
                if (m_fcnt == FILT - 1) begin
                    m_start = m_filt; m_filt = pg; m_fcnt = 0;
                end else m_fcnt++;
            end else m_fcnt = 0;
            low_pad = !((mn | bt) | other_low);
            void'(q_warn.pop_front()); q_warn.push_back(b_warn);
            void'(q_min.pop_front());  q_min.push_back(b_min);
            void'(q_batt.pop_front()); q_batt.push_back(b_batt);
            void'(q_ext.pop_front());  q_ext.push_back(ext_rst);
            void'(q_pad.pop_front());  q_pad.push_back(low_pad);
            void'(q_prog.pop_front()); q_prog.push_back(prog_n);
        end
    end

    string phase = "R1";

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", tag, phase, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (arst_n && !done) begin
            check("R3",  "rst_pad_drive_o", pad_drive, q_min[0] | q_batt[0]);
            check("R4",  "core_rst_o", core_rst, m_rst);
            check("R8",  "warn_irq_o", irq, m_irq);
            check("R8",  "warn_vec_o", vec, m_irq ? 8'h2B : 8'h00);
            check("R10", "batt_mode_n_o", batt_n, !q_batt[0]);
            check("R11", "boot_req_o", boot_req, !m_filt);
            check("R12", "boot_start_o", boot_start, m_start);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_irq(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (irq) cnt++;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        int n;
        tick(3);
        #1 arst_n = 1'b1;
        tick(1);
        phase = "R1";
        check("R1", "core_rst_o after clear", core_rst, 1);
        check("R1", "rst_pad_drive_o after clear", pad_drive, 1);
        check("R1", "batt_mode_n_o after clear", batt_n, 0);
        check("R1", "warn_irq_o after clear", irq, 0);
        check("R1", "boot_req_o after clear", boot_req, 0);

        phase = "R4 power up";
        #1 b_batt = 1'b0;
        tick(5); #1 b_min = 1'b0;
        tick(5); #1 b_warn = 1'b0;
        tick(POR - 20);
        check("R4", "reset held during count", core_rst, 1);
        tick(40);
        check("R4", "reset released", core_rst, 0);

        phase = "R2 latency";
        #1 b_min = 1'b1;
        tick(1);
        check("R2", "pad drive after one edge", pad_drive, 0);
        tick(1);
        check("R2", "pad drive after two edges", pad_drive, 1);
        tick(1);
        check("R3", "core reset with low supply", core_rst, 1);
        #1 b_min = 1'b0;
        tick(POR + 20);

        phase = "R5 restart";
        #1 b_min = 1'b1;
        tick(5); #1 b_min = 1'b0;
        tick(100); #1 ext_rst = 1'b1;
        tick(1); #1 ext_rst = 1'b0;
        tick(150);
        check("R5", "count restarted by short cause", core_rst, 1);
        tick(80);
        check("R5", "released after restarted count", core_rst, 0);

        phase = "R6 external reset";
        #1 ext_rst = 1'b1;
        tick(20);
        check("R6", "core reset from external input", core_rst, 1);
        check("R6", "pad not driven by external input", pad_drive, 0);
        #1 ext_rst = 1'b0;
        tick(POR + 20);
        check("R6", "released after external reset", core_rst, 0);

        phase = "R7 shared pad";
        #1 other_low = 1'b1;
        tick(10);
        check("R7", "core reset from pad pulled low", core_rst, 1);
        #1 other_low = 1'b0;
        tick(POR - 20);
        check("R7", "count restarted after pad release", core_rst, 1);
        tick(40);

        phase = "R8 warning";
        #1 b_warn = 1'b1;
        count_irq(30, n);
        check("R8", "one request per crossing", n, 1);
        #1 b_warn = 1'b0;
        tick(5);

        phase = "R9 disabled";
        #1 warn_en = 1'b0; b_warn = 1'b1;
        count_irq(10, n);
        check("R9", "no request when disabled", n, 0);
        #1 b_warn = 1'b0; warn_en = 1'b1;
        tick(5);

        phase = "R9 in reset";
        #1 b_min = 1'b1;
        tick(5); #1 b_warn = 1'b1;
        count_irq(10, n);
        check("R9", "no request during reset", n, 0);
        #1 b_min = 1'b0;
        tick(POR + 20);
        count_irq(5, n);
        check("R9", "held level gives no late request", n, 0);
        #1 b_warn = 1'b0;
        tick(5); #1 b_warn = 1'b1;
        count_irq(10, n);
        check("R9", "request after re-arm", n, 1);
        #1 b_warn = 1'b0;
        tick(5);

        phase = "R10 backup";
        #1 b_batt = 1'b1;
        tick(4);
        check("R10", "backup indication low", batt_n, 0);
        check("R10", "core reset on backup", core_rst, 1);
        #1 b_batt = 1'b0;
        tick(POR + 20);
        check("R10", "backup indication high", batt_n, 1);

        phase = "R11 filter";
        #1 prog_n = 1'b0;
        tick(30); #1 prog_n = 1'b1;
        tick(10);
        check("R11", "short low ignored", boot_req, 0);
        tick(50); #1 prog_n = 1'b0;
        n = 0;
        for (int i = 0; i < 70; i++) begin
            tick(1);
            if (boot_start) n++;
        end
        check("R11", "request after long low", boot_req, 1);
        check("R12", "single start pulse", n, 1);
        #1 prog_n = 1'b1;
        tick(30); #1 prog_n = 1'b0;
        tick(10);
        check("R11", "short high ignored", boot_req, 1);
        #1 prog_n = 1'b1;
        n = 0;
        for (int i = 0; i < 70; i++) begin
            tick(1);
            if (boot_start) n++;
        end
        check("R11", "request cleared after long high", boot_req, 0);
        check("R12", "no pulse on release", n, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule